// File: doc/BRIEF.md
# Multi-Vector FP32 Round-Up Unit

This block executes one vector instruction. It rounds every 32-bit single-precision lane of a group of two or four consecutive vector registers up, toward plus infinity, to an integral value. Each result stays in single-precision format. The results go to a destination group of the same size. The unit holds its own register file of 32 registers, each VL bits wide. A host loads and inspects that file through one write port and one read port.

An operation starts with a one-cycle `start` pulse together with a 32-bit instruction word. The unit checks the fixed opcode bits and picks the group size from bit 20. It forms the source and destination base indices from scaled fields. It then reads and rounds the whole source group in one cycle and holds the results in a capture buffer. After that it writes one destination register per cycle. `done` pulses once the last write is made. A malformed word raises `undef` with `done` and leaves every register untouched.

Top module: `vec_ceil_unit`

## Requirements
- R1: A positive lane that is not integral becomes the next integral value above it, encoded in FP32, including when the significand carries into the exponent (0x3FFFFFFF gives 0x40000000, 0x4AFFFFFF gives 0x4B000000).
- R2: A negative lane with magnitude of at least 1 that is not integral moves toward zero (0xBFC00000 gives 0xBF800000). A lane strictly between -1 and 0 gives -0.0 (0x80000000).
- R3: A positive lane strictly between 0 and 1, subnormals included, gives +1.0 (0x3F800000). +0 and -0 come out unchanged.
- R4: These lanes come out unchanged: lanes whose biased exponent is 150 or more, lanes that are already integral, and both infinities. A NaN lane comes out with bit 22 set and all its other bits kept.
- R5: Each register holds VL/32 lanes, with lane k at bits 32k+31 down to 32k. Every lane of every register in the group is processed.
- R6: With bit 20 clear, the word is the two-register form. The source base is bits 9:6 times 2 and the destination base is bits 4:1 times 2. Bits 5 and 0 must be zero.
- R7: With bit 20 set, the word is the four-register form. The source base is bits 9:7 times 4 and the destination base is bits 4:2 times 4. Bits 6:5 and 1:0 must be zero.
- R8: All source lanes are captured before any destination register is written, so a destination group equal to the source group gets the correct rounded values.
- R9: A word is undefined if bits 31:21 differ from 0b11000001101, if bits 19:10 differ from 0b1001111000, or if a required zero bit is set. Such a word gives `undef` and `done` on the first clock edge after `start`, and no register changes.
- R10: Registers outside the destination group keep their contents through an operation.
- R11: After reset, `busy`, `done` and `undef` are low. `busy` is high in the cycle after an accepted start. `done` is a one-cycle pulse. Counting the edge that samples `start` as edge 1, `done` rises on edge N+2 for an N-register group.
- R12: A host write presented while `busy` is high is dropped. The host read port returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined instruction, pulses with done |
| host_we | input | 1 | Host register write enable |
| host_widx | input | 5 | Host write register index |
| host_wdata | input | VL | Host write data |
| host_ridx | input | 5 | Host read register index |
| host_rdata | output | VL | Host read data |

## Verification
A fixed table of corner lanes is run through one four-register operation. The table holds carries into the exponent, negative fractions that must truncate, tiny positives, subnormals, signed zeros, infinities, NaNs and values just under and just over the exponent where rounding stops. Each lane's result separates one rounding branch from the others. Random operations use mixed values whose exponents cluster around the rounding boundary, with random group sizes and random base fields. They tell the two field scalings apart, and they show whether writes leak outside the destination group. In-place groups detect a design that writes before it has read everything. Corrupted opcode and padding bits, and a host write poked in mid-operation, separate rejection from silent execution.

// File: rtl/vcu_pkg.sv
package vcu_pkg;
  localparam int NREG   = 32;
  localparam int IDXW   = 5;
  localparam int LANEW  = 32;
  localparam int MAXGRP = 4;
  localparam int SELW   = 2;

  localparam logic [10:0] OPC_HI = 11'b11000001101;
  localparam logic [9:0]  OPC_LO = 10'b1001111000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;

  typedef struct packed {
    logic            ok;
    logic            four;
    logic [IDXW-1:0] src;
    logic [IDXW-1:0] dst;
  } dec_t;
endpackage

// File: rtl/vcu_decode.sv
module vcu_decode
  import vcu_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic opc_ok;
  logic pad_ok;

  always_comb begin
    opc_ok = (instr_i[31:21] == OPC_HI) && (instr_i[19:10] == OPC_LO);
    if (instr_i[20]) begin
      pad_ok     = (instr_i[6:5] == 2'b00) && (instr_i[1:0] == 2'b00);
      dec_o.src  = {instr_i[9:7], 2'b00};
      dec_o.dst  = {instr_i[4:2], 2'b00};
    end else begin
      pad_ok     = (instr_i[5] == 1'b0) && (instr_i[0] == 1'b0);
      dec_o.src  = {instr_i[9:6], 1'b0};
      dec_o.dst  = {instr_i[4:1], 1'b0};
    end
    dec_o.four = instr_i[20];
    dec_o.ok   = opc_ok && pad_ok;
  end
endmodule

// File: rtl/vcu_ceil_lane.sv
module vcu_ceil_lane (
  input  logic [31:0] x_i,
  output logic [31:0] y_o
);
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] man;
  logic [4:0]  fbits;
  logic [22:0] fmask;
  logic [24:0] sig;

  always_comb begin
    sgn   = x_i[31];
    ex    = x_i[30:23];
    man   = x_i[22:0];
    fbits = 5'(8'd150 - ex);
    fmask = 23'((24'd1 << fbits) - 24'd1);
    sig   = '0;
    y_o   = x_i;
    if (ex == 8'hFF) begin
      if (man != '0) y_o = x_i | 32'h0040_0000;
    end else if (ex >= 8'd150) begin
      y_o = x_i;
    end else if (ex == 8'd0 && man == '0) begin
      y_o = x_i;
    end else if (ex < 8'd127) begin
      y_o = sgn ? 32'h8000_0000 : 32'h3F80_0000;
    end else if ((man & fmask) != '0) begin
      if (sgn) begin
        y_o = {sgn, ex, man & ~fmask};
      end else begin
        sig = {2'b01, man & ~fmask} + (25'd1 << fbits);
        if (sig[24]) y_o = {1'b0, ex + 8'd1, 23'd0};
        else         y_o = {1'b0, ex, sig[22:0]};
      end
    end
  end

  always_comb begin
    AST_SIGN_KEPT: assert ((x_i[30:23] == 8'hFF && x_i[22:0] != '0) || (y_o[31] == x_i[31])); // R2
  end
endmodule

// File: rtl/vcu_regfile.sv
module vcu_regfile
  import vcu_pkg::*;
#(
  parameter int VL  = 128,
  parameter int NRD = 5
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [IDXW-1:0]          widx_i,
  input  logic [VL-1:0]            wdata_i,
  input  logic [NRD-1:0][IDXW-1:0] ridx_i,
  output logic [NRD-1:0][VL-1:0]   rdata_o
);
  logic [VL-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem[ridx_i[p]];
  end
endmodule

// File: rtl/vcu_ctrl.sv
module vcu_ctrl
  import vcu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  dec_t            dec_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            undef_o,
  output logic            cap_o,
  output logic            we_o,
  output logic [IDXW-1:0] widx_o,
  output logic [SELW-1:0] sel_o,
  output logic [IDXW-1:0] src_o
);
  st_e             st_q, st_d;
  logic [SELW-1:0] cnt_q, cnt_d;
  logic            four_q, four_d;
  logic [IDXW-1:0] src_q, src_d;
  logic [IDXW-1:0] dst_q, dst_d;
  logic            done_q, done_d;
  logic            undef_q, undef_d;
  logic [SELW-1:0] last;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    four_d  = four_q;
    src_d   = src_q;
    dst_d   = dst_q;
    done_d  = 1'b0;
    undef_d = 1'b0;
    cap_o   = 1'b0;
    we_o    = 1'b0;
    last    = four_q ? 2'd3 : 2'd1;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!dec_i.ok) begin
            done_d  = 1'b1;
            undef_d = 1'b1;
          end else begin
            st_d   = ST_CAPT;
            four_d = dec_i.four;
            src_d  = dec_i.src;
            dst_d  = dec_i.dst;
          end
        end
      end
      ST_CAPT: begin
        cap_o = 1'b1;
        cnt_d = '0;
        st_d  = ST_WRITE;
      end
      ST_WRITE: begin
        we_o  = 1'b1;
        cnt_d = cnt_q + 2'd1;
        if (cnt_q == last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      four_q  <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      four_q  <= four_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      done_q  <= done_d;
      undef_q <= undef_d;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign undef_o = undef_q;
  assign widx_o  = dst_q + IDXW'(cnt_q);
  assign sel_o   = cnt_q;
  assign src_o   = src_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    undef_q |-> (!we_o && st_q == ST_IDLE)); // R9
  AST_WRITE_AFTER_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && cnt_q == '0) |-> $past(cap_o)); // R8
  AST_CNT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (four_q ? 1'b1 : (cnt_q <= 2'd1))); // R10
endmodule

// File: rtl/vec_ceil_unit.sv
module vec_ceil_unit
  import vcu_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  output logic            busy,
  output logic            done,
  output logic            undef,
  input  logic            host_we,
  input  logic [IDXW-1:0] host_widx,
  input  logic [VL-1:0]   host_wdata,
  input  logic [IDXW-1:0] host_ridx,
  output logic [VL-1:0]   host_rdata
);
  localparam int LANES = VL / LANEW;
  localparam int NRD   = MAXGRP + 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dec_t            dec;
  logic            cap;
  logic            eng_we;
  logic [IDXW-1:0] eng_widx;
  logic [SELW-1:0] eng_sel;
  logic [IDXW-1:0] src_base;

  vcu_decode u_decode (
    .instr_i (instr),
    .dec_o   (dec)
  );

  vcu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start),
    .dec_i   (dec),
    .busy_o  (busy),
    .done_o  (done),
    .undef_o (undef),
    .cap_o   (cap),
    .we_o    (eng_we),
    .widx_o  (eng_widx),
    .sel_o   (eng_sel),
    .src_o   (src_base)
  );

  logic [NRD-1:0][IDXW-1:0]  rd_idx;
  logic [NRD-1:0][VL-1:0]    rd_data;
  logic [MAXGRP-1:0][VL-1:0] rnd;
  logic [MAXGRP-1:0][VL-1:0] res_q;

  for (genvar g = 0; g < MAXGRP; g++) begin : g_grp
    assign rd_idx[g] = src_base + IDXW'(g);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      vcu_ceil_lane u_lane (
        .x_i (rd_data[g][l*LANEW +: LANEW]),
        .y_o (rnd[g][l*LANEW +: LANEW])
      );
    end
  end
  assign rd_idx[MAXGRP] = host_ridx;
  assign host_rdata     = rd_data[MAXGRP];

  always_ff @(posedge clk) begin
    if (cap) res_q <= rnd;
  end

  logic            rf_we;
  logic [IDXW-1:0] rf_widx;
  logic [VL-1:0]   rf_wdata;

  always_comb begin
    rf_we    = eng_we | (host_we & ~busy);
    rf_widx  = eng_we ? eng_widx : host_widx;
    rf_wdata = eng_we ? res_q[eng_sel] : host_wdata;
  end

  vcu_regfile #(.VL(VL), .NRD(NRD)) u_rf (
    .clk     (clk),
    .we_i    (rf_we),
    .widx_i  (rf_widx),
    .wdata_i (rf_wdata),
    .ridx_i  (rd_idx),
    .rdata_o (rd_data)
  );

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eng_we && eng_sel != '0) |-> $stable(res_q)); // R8
endmodule

// File: tb/vec_ceil_unit_tb.sv
module vec_ceil_unit_tb;
  localparam int VL = 128;
  localparam int LN = VL / 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [31:0]   instr;
  logic          busy, done, undef;
  logic          host_we;
  logic [4:0]    host_widx, host_ridx;
  logic [VL-1:0] host_wdata, host_rdata;

  int errors = 0;
  int checks = 0;
  logic [VL-1:0] mdl [32];
  logic [31:0] cin [16];
  logic [31:0] cexp [16];
  string       ctag [16];

  always #10 clk = ~clk;

  vec_ceil_unit #(.VL(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done), .undef(undef),
    .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_ridx(host_ridx), .host_rdata(host_rdata)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_ceil(input logic [31:0] x);
    logic [7:0]  e;
    logic [24:0] sig, n, t;
    int          sh, p;
    e = x[30:23];
    if (e == 8'hFF) return (x[22:0] != 0) ? (x | 32'h0040_0000) : x;
    if (e >= 8'd150 || x[30:0] == 0) return x;
    if (e < 8'd127) return x[31] ? 32'h8000_0000 : 32'h3F80_0000;
    sh  = 150 - int'(e);
    sig = {2'b01, x[22:0]};
    n   = sig >> sh;
    if (!x[31] && ((sig & ((25'd1 << sh) - 25'd1)) != 0)) n = n + 25'd1;
    p = 0;
    for (int i = 0; i < 25; i++) if (n[i]) p = i;
    t = n << (23 - p);
    return {x[31], 8'(127 + p), t[22:0]};
  endfunction

  function automatic logic [31:0] gen_val();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: gen_val = r;
      1, 2: gen_val = {r[31], 8'(120 + $urandom % 35), r[22:0]};
      3: gen_val = {r[31], 8'($urandom % 127), r[22:0]};
      4: gen_val = {r[31], 31'd0};
      5: gen_val = {r[31], 8'hFF, (r[0] ? r[22:0] : 23'd0)};
      6: gen_val = {r[31], 8'(127 + $urandom % 23), 23'h7FFFFF};
      default: gen_val = {r[31], 8'(127 + $urandom % 23), r[22:8], 8'd0};
    endcase
  endfunction

  function automatic logic [31:0] mk_instr(input logic four, input logic [3:0] zn, input logic [3:0] zd);
    if (four) return {11'b11000001101, 1'b1, 10'b1001111000, zn[2:0], 2'b00, zd[2:0], 2'b00};
    return {11'b11000001101, 1'b0, 10'b1001111000, zn, 1'b0, zd, 1'b0};
  endfunction

  task automatic host_write(input int idx, input logic [VL-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_widx = 5'(idx); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    mdl[idx] = d;
  endtask

  task automatic load_all();
    logic [VL-1:0] d;
    for (int r = 0; r < 32; r++) begin
      for (int l = 0; l < LN; l++) d[l*32 +: 32] = gen_val();
      host_write(r, d);
    end
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < 32; r++) begin
      host_ridx = 5'(r);
      #1;
      for (int l = 0; l < LN; l++)
        check32($sformatf("%s reg %0d lane %0d", tag, r, l), host_rdata[l*32 +: 32], mdl[r][l*32 +: 32]);
    end
  endtask

  task automatic apply_model(input logic four, input logic [3:0] zn, input logic [3:0] zd);
    logic [VL-1:0] tmp [4];
    int n, s, d;
    n = four ? 4 : 2;
    s = four ? int'(zn[2:0]) * 4 : int'(zn) * 2;
    d = four ? int'(zd[2:0]) * 4 : int'(zd) * 2;
    for (int r = 0; r < n; r++)
      for (int l = 0; l < LN; l++) tmp[r][l*32 +: 32] = ref_ceil(mdl[s + r][l*32 +: 32]);
    for (int r = 0; r < n; r++) mdl[d + r] = tmp[r];
  endtask

  task automatic run_op(input logic [31:0] iw, input int exp_lat, input logic exp_undef,
                        input bit poke, input int poke_idx, input string tag);
    int lat;
    @(negedge clk);
    instr = iw; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    check32({tag, " R11 busy after start"}, 32'(busy), 32'(!exp_undef));
    if (poke) begin
      host_we = 1'b1; host_widx = 5'(poke_idx); host_wdata = {LN{32'hDEADBEEF}};
    end
    while (!done && lat < 40) begin
      @(negedge clk);
      host_we = 1'b0;
      lat++;
    end
    host_we = 1'b0;
    check32({tag, " R11 done latency"}, 32'(lat), 32'(exp_lat));
    check32({tag, " R9 undef flag"}, 32'(undef), 32'(exp_undef));
    @(negedge clk);
    check32({tag, " R11 done pulse width"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic        four;
    logic [3:0]  zn, zd;
    void'($urandom(32'd20240607));
    cin[0]  = 32'h3FC00000; cexp[0]  = 32'h40000000; ctag[0]  = "R1";
    cin[1]  = 32'h40490FDB; cexp[1]  = 32'h40800000; ctag[1]  = "R1";
    cin[2]  = 32'h3FFFFFFF; cexp[2]  = 32'h40000000; ctag[2]  = "R1";
    cin[3]  = 32'h4AFFFFFF; cexp[3]  = 32'h4B000000; ctag[3]  = "R1";
    cin[4]  = 32'hBFC00000; cexp[4]  = 32'hBF800000; ctag[4]  = "R2";
    cin[5]  = 32'hBF000000; cexp[5]  = 32'h80000000; ctag[5]  = "R2";
    cin[6]  = 32'hC0490FDB; cexp[6]  = 32'hC0400000; ctag[6]  = "R2";
    cin[7]  = 32'h3E800000; cexp[7]  = 32'h3F800000; ctag[7]  = "R3";
    cin[8]  = 32'h00000001; cexp[8]  = 32'h3F800000; ctag[8]  = "R3";
    cin[9]  = 32'h80000000; cexp[9]  = 32'h80000000; ctag[9]  = "R3";
    cin[10] = 32'h00000000; cexp[10] = 32'h00000000; ctag[10] = "R3";
    cin[11] = 32'h7F800000; cexp[11] = 32'h7F800000; ctag[11] = "R4";
    cin[12] = 32'hFF800000; cexp[12] = 32'hFF800000; ctag[12] = "R4";
    cin[13] = 32'h7F800001; cexp[13] = 32'h7FC00001; ctag[13] = "R4";
    cin[14] = 32'h4B000001; cexp[14] = 32'h4B000001; ctag[14] = "R4";
    cin[15] = 32'h3F800000; cexp[15] = 32'h3F800000; ctag[15] = "R4";

    rst_n = 1'b0; start = 1'b0; instr = '0;
    host_we = 1'b0; host_widx = '0; host_wdata = '0; host_ridx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R11 reset busy", 32'(busy), 32'd0);
    check32("R11 reset done", 32'(done), 32'd0);
    check32("R11 reset undef", 32'(undef), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    load_all();
    for (int r = 0; r < 4; r++) begin
      logic [VL-1:0] d;
      for (int l = 0; l < LN; l++) d[l*32 +: 32] = cin[(r*LN + l) % 16];
      host_write(4 + r, d);
    end
    run_op(mk_instr(1'b1, 4'd1, 4'd5), 6, 1'b0, 1'b0, 0, "R7");
    apply_model(1'b1, 4'd1, 4'd5);
    for (int r = 0; r < 4; r++) begin
      host_ridx = 5'(20 + r);
      #1;
      for (int l = 0; l < LN; l++)
        check32($sformatf("%s corner %0d", ctag[(r*LN + l) % 16], (r*LN + l) % 16),
                host_rdata[l*32 +: 32], cexp[(r*LN + l) % 16]);
    end
    check_all("R7 R5 R10");

    run_op(mk_instr(1'b0, 4'd7, 4'd13), 4, 1'b0, 1'b0, 0, "R6");
    apply_model(1'b0, 4'd7, 4'd13);
    check_all("R6 R10");

    run_op(mk_instr(1'b1, 4'd2, 4'd2), 6, 1'b0, 1'b0, 0, "R8");
    apply_model(1'b1, 4'd2, 4'd2);
    check_all("R8 four in place");

    run_op(mk_instr(1'b0, 4'd4, 4'd4), 4, 1'b0, 1'b1, 30, "R12");
    apply_model(1'b0, 4'd4, 4'd4);
    check_all("R8 R12 host write dropped");

    run_op(mk_instr(1'b0, 4'd3, 4'd5) ^ 32'h8000_0000, 1, 1'b1, 1'b0, 0, "R9 opcode");
    run_op(mk_instr(1'b0, 4'd3, 4'd5) | 32'h0000_0020, 1, 1'b1, 1'b0, 0, "R9 pad5");
    run_op(mk_instr(1'b1, 4'd1, 4'd2) | 32'h0000_0040, 1, 1'b1, 1'b0, 0, "R9 pad6");
    run_op(mk_instr(1'b1, 4'd1, 4'd2) | 32'h0000_0002, 1, 1'b1, 1'b0, 0, "R9 pad1");
    run_op(mk_instr(1'b1, 4'd1, 4'd2) ^ 32'h0000_0400, 1, 1'b1, 1'b0, 0, "R9 low opcode");
    check_all("R9 no write");

    for (int k = 0; k < 30; k++) begin
      load_all();
      four = 1'($urandom);
      zn   = 4'($urandom);
      zd   = 4'($urandom);
      run_op(mk_instr(four, zn, zd), four ? 6 : 4, 1'b0, 1'b0, 0, "R6 R7 random");
      apply_model(four, zn, zd);
      check_all("R1 R2 R3 R4 R5 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule